// File: doc/BRIEF.md
# Word-Mode I/O Access Decoder

This block is the target-side register window of a bus peripheral. It spans a 32-byte I/O space. Each access arrives as a 5-bit byte offset, a 4-bit active-low byte-enable field, a write flag and 32 bits of write data. In 16-bit mode the decoder checks the enable pattern against the offset. It then steers the access to one of five places: a 16-byte station-address store, the primary data port, a 7-bit register pointer, the reset port or an auxiliary data port. The store and the pointer live inside the block. The three ports are exposed as one-cycle read and write strobes, so the register file and the reset logic that sit behind them can act.

Any combination outside the legal set is flagged and has no effect. A full 32-bit write to the primary data port latches a sticky 32-bit mode flag. From then on the 16-bit decode stands aside and every access is passed on unclassified. Only the hardware reset or the software reset input clears the flag. All outputs are registered and appear one clock after the access is presented.

Top module: `io_win_dec`

## Requirements
- R1: At offset 10h with enables 1100 and at offset 14h with enables 1100, a read or a write raises the matching data-port or reset-port strobe. At offset 16h with enables 0011 it raises the auxiliary-port strobe. Exactly one strobe is raised, for one cycle. A read returns that port's input word. A write presents, on `wrData`, bits [15:0] of the bus for enables 1100 and bits [31:16] for enables 0011.
- R2: Byte reads of the store are legal with enables 1110, 1101, 1011 and 0111 at offset bits [1:0] = 00, 01, 10 and 11. The read returns the addressed store byte in bits [7:0], with zeros above.
- R3: Word reads and word writes of the store are legal with enables 1100 at offset bits [1:0] = 00 and with enables 0011 at bits [1:0] = 10. The even store byte is the low half of the word and the odd store byte is the high half.
- R4: The pointer at offset 12h (enables 0011) keeps the low 7 bits of the selected write half. It reads back zero-extended to 16 bits and is always visible on `ptrSel`. Both the hardware reset and `softReset` return it to 0.
- R5: These accesses are illegal: every other enable/offset combination, every access to 18h–1Fh, and every read with enables 0000. An illegal access pulses `illegal` for one cycle. It raises no strobe and changes neither the store nor the pointer. An illegal read returns FFFFh with `rdValid`.
- R6: A write with enables 0000 at offset 10h sets `dwordMode`. It also raises the data-port write strobe, with bits [15:0] of the bus on `wrData`.
- R7: Once `dwordMode` is set, it stays set until the hardware reset or `softReset`. Further accesses and idle cycles do not clear it.
- R8: While `dwordMode` is set, each access gives only a one-cycle `passThru` pulse. It gives no strobe, no `illegal` and no `rdValid`, and it does not change the store or the pointer.
- R9: After the hardware reset all pulses are low, `dwordMode` is 0, `ptrSel` is 0, `rdData` is 0 and the store holds zeros. Every output answers one clock after the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| softReset | input | 1 | Software reset; clears the mode flag and the pointer |
| accValid | input | 1 | An access is presented this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accOffset | input | 5 | Byte offset within the 32-byte window |
| accBeN | input | 4 | Byte enables, active low, one per byte lane |
| accWdata | input | 32 | Write data on all four lanes |
| dataPortIn | input | 16 | Read value of the primary data port |
| resetPortIn | input | 16 | Read value of the reset port |
| auxPortIn | input | 16 | Read value of the auxiliary data port |
| rdData | output | 16 | Read result, held until the next read |
| rdValid | output | 1 | Pulse: a read in 16-bit mode completed |
| illegal | output | 1 | Pulse: the access was not legal |
| passThru | output | 1 | Pulse: the access was passed on in 32-bit mode |
| dataPortRd | output | 1 | Pulse: primary data port read |
| dataPortWr | output | 1 | Pulse: primary data port write |
| resetPortRd | output | 1 | Pulse: reset port read |
| resetPortWr | output | 1 | Pulse: reset port write |
| auxPortRd | output | 1 | Pulse: auxiliary port read |
| auxPortWr | output | 1 | Pulse: auxiliary port write |
| wrData | output | 16 | Lane-selected write word for port writes |
| ptrSel | output | 7 | Current register pointer |
| dwordMode | output | 1 | Sticky 32-bit mode flag |

## Verification
The assertions assume that `softReset` stays low while `rstN` is low and in the cycle right after it rises. They also assume that `accValid` is a one-cycle qualifier, with offset, enables and data stable in that cycle. The bench drives every access at the falling edge and drops `accValid` one cycle later. It pulses `softReset` only between accesses, so it never exercises a software reset on the same edge as an access. Every access goes through one task, which keeps the stimulus inside these limits.

// File: rtl/io_win_pkg.sv
package io_win_pkg;

  // Per-access control word handed from the decoder to the datapath
  typedef struct packed {
    logic rd;       // read in 16-bit mode (legal or not)
    logic illegal;  // access rejected
    logic pass;     // 32-bit mode: passed on unclassified
    logic storeRd;
    logic storeWr;
    logic byteAcc;  // store read is a single byte
    logic hiHalf;   // upper lane pair selected
    logic ptrRd;
    logic ptrWr;
    logic dpRd;
    logic dpWr;
    logic rstRd;
    logic rstWr;
    logic auxRd;
    logic auxWr;
  } ctlStb_t;

endpackage

// File: rtl/io_win_ctrl.sv
module io_win_ctrl
  import io_win_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int BE_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softReset,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [OFF_W-1:0] accOffset,
  input  logic [BE_W-1:0]  accBeN,
  output ctlStb_t          stb,
  output logic             dwordMode
);

  localparam int HI = OFF_W - 1;
  localparam logic [OFF_W-1:0] DP_OFF = {1'b1, {(OFF_W-1){1'b0}}};
  localparam logic [BE_W-1:0] LO_PAIR = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};
  localparam logic [BE_W-1:0] HI_PAIR = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};

  logic             modeQ;
  logic [BE_W-1:0]  byteMask;
  logic             byteOk, wordLo, wordHi, wordOk;
  logic             isStore, isPort, isDword;

  always_comb begin
    byteMask = ~(BE_W'(1) << accOffset[1:0]);
    byteOk   = (accBeN == byteMask);
    wordLo   = (accOffset[1:0] == 2'b00) && (accBeN == LO_PAIR);
    wordHi   = (accOffset[1:0] == 2'b10) && (accBeN == HI_PAIR);
    wordOk   = wordLo || wordHi;
    isStore  = !accOffset[HI];
    isPort   = (accOffset[HI:HI-1] == 2'b10);
    isDword  = accWrite && (accOffset == DP_OFF) && (accBeN == '0);
  end

  always_comb begin
    stb = '0;
    if (accValid) begin
      if (modeQ) begin
        stb.pass = 1'b1;
      end else begin
        stb.rd     = !accWrite;
        stb.hiHalf = accOffset[1];
        if (isDword) begin
          stb.dpWr = 1'b1;
        end else if (isStore && !accWrite && (byteOk || wordOk)) begin
          stb.storeRd = 1'b1;
          stb.byteAcc = byteOk;
        end else if (isStore && accWrite && wordOk) begin
          stb.storeWr = 1'b1;
        end else if (isPort && wordOk) begin
          unique case (accOffset[2:1])
            2'b00:   if (accWrite) stb.dpWr  = 1'b1; else stb.dpRd  = 1'b1;
            2'b01:   if (accWrite) stb.ptrWr = 1'b1; else stb.ptrRd = 1'b1;
            2'b10:   if (accWrite) stb.rstWr = 1'b1; else stb.rstRd = 1'b1;
            default: if (accWrite) stb.auxWr = 1'b1; else stb.auxRd = 1'b1;
          endcase
        end else begin
          stb.illegal = 1'b1;
        end
      end
    end
  end

  // Sticky 32-bit mode flag: only the two resets clear it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            modeQ <= 1'b0;
    else if (softReset)                   modeQ <= 1'b0;
    else if (accValid && !modeQ && isDword) modeQ <= 1'b1;
  end

  assign dwordMode = modeQ;

  assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && !softReset) |=> modeQ);

  assert_mode_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && accOffset == DP_OFF && accBeN == '0 && !softReset) |=> modeQ);

  assert_soft_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> !modeQ);

endmodule

// File: rtl/io_win_dp.sv
module io_win_dp
  import io_win_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PTR_W       = 7,
  parameter int STORE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    softReset,
  input  ctlStb_t                 stb,
  input  logic [$clog2(STORE_BYTES)-1:0] accOffset,
  input  logic [2*DATA_W-1:0]     accWdata,
  input  logic [DATA_W-1:0]       dataPortIn,
  input  logic [DATA_W-1:0]       resetPortIn,
  input  logic [DATA_W-1:0]       auxPortIn,
  output logic [DATA_W-1:0]       rdData,
  output logic                    rdValid,
  output logic                    illegal,
  output logic                    passThru,
  output logic                    dataPortRd,
  output logic                    dataPortWr,
  output logic                    resetPortRd,
  output logic                    resetPortWr,
  output logic                    auxPortRd,
  output logic                    auxPortWr,
  output logic [DATA_W-1:0]       wrData,
  output logic [PTR_W-1:0]        ptrSel
);

  localparam int AW = $clog2(STORE_BYTES);
  localparam int BW = DATA_W / 2;

  logic [BW-1:0]     storeQ [STORE_BYTES];
  logic [DATA_W-1:0] wSel, rdNext;
  logic [AW-1:0]     baseIdx, oddIdx;
  logic [PTR_W-1:0]  ptrQ;
  logic [DATA_W-1:0] rdDataQ, wrDataQ;
  logic rdValidQ, illegalQ, passQ;
  logic dpRdQ, dpWrQ, rstRdQ, rstWrQ, auxRdQ, auxWrQ;

  assign wSel    = stb.hiHalf ? accWdata[DATA_W +: DATA_W] : accWdata[0 +: DATA_W];
  assign baseIdx = {accOffset[AW-1:1], 1'b0};
  assign oddIdx  = {accOffset[AW-1:1], 1'b1};

  // One register per store byte; a word write covers an even/odd pair
  for (genvar i = 0; i < STORE_BYTES; i++) begin : g_store
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   storeQ[i] <= '0;
      else if (stb.storeWr && baseIdx == AW'(i))   storeQ[i] <= wSel[BW-1:0];
      else if (stb.storeWr && oddIdx == AW'(i))    storeQ[i] <= wSel[DATA_W-1:BW];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ptrQ <= '0;
    else if (softReset) ptrQ <= '0;
    else if (stb.ptrWr) ptrQ <= wSel[PTR_W-1:0];
  end

  always_comb begin
    rdNext = '0;
    if (stb.illegal)      rdNext = '1;
    else if (stb.storeRd) rdNext = stb.byteAcc ? DATA_W'(storeQ[accOffset])
                                               : {storeQ[oddIdx], storeQ[baseIdx]};
    else if (stb.ptrRd)   rdNext = DATA_W'(ptrQ);
    else if (stb.dpRd)    rdNext = dataPortIn;
    else if (stb.rstRd)   rdNext = resetPortIn;
    else if (stb.auxRd)   rdNext = auxPortIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      wrDataQ  <= '0;
      rdValidQ <= 1'b0;
      illegalQ <= 1'b0;
      passQ    <= 1'b0;
      dpRdQ    <= 1'b0;
      dpWrQ    <= 1'b0;
      rstRdQ   <= 1'b0;
      rstWrQ   <= 1'b0;
      auxRdQ   <= 1'b0;
      auxWrQ   <= 1'b0;
    end else begin
      if (stb.rd) rdDataQ <= rdNext;
      if (stb.dpWr || stb.rstWr || stb.auxWr) wrDataQ <= wSel;
      rdValidQ <= stb.rd;
      illegalQ <= stb.illegal;
      passQ    <= stb.pass;
      dpRdQ    <= stb.dpRd;
      dpWrQ    <= stb.dpWr;
      rstRdQ   <= stb.rstRd;
      rstWrQ   <= stb.rstWr;
      auxRdQ   <= stb.auxRd;
      auxWrQ   <= stb.auxWr;
    end
  end

  assign rdData      = rdDataQ;
  assign rdValid     = rdValidQ;
  assign illegal     = illegalQ;
  assign passThru    = passQ;
  assign dataPortRd  = dpRdQ;
  assign dataPortWr  = dpWrQ;
  assign resetPortRd = rstRdQ;
  assign resetPortWr = rstWrQ;
  assign auxPortRd   = auxRdQ;
  assign auxPortWr   = auxWrQ;
  assign wrData      = wrDataQ;
  assign ptrSel      = ptrQ;

  assert_one_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({illegalQ, passQ, dpRdQ, dpWrQ, rstRdQ, rstWrQ, auxRdQ, auxWrQ}));

  assert_illegal_ones_R5: assert property (@(posedge clk) disable iff (!rstN)
    (illegalQ && rdValidQ) |-> (rdDataQ == '1));

  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(softReset) |-> (ptrQ == '0));

  assert_pass_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    passQ |-> !rdValidQ);

endmodule

// File: rtl/io_win_dec.sv
module io_win_dec
  import io_win_pkg::*;
#(
  parameter int OFF_W       = 5,
  parameter int BE_W        = 4,
  parameter int DATA_W      = 16,
  parameter int PTR_W       = 7,
  parameter int STORE_BYTES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softReset,
  input  logic                accValid,
  input  logic                accWrite,
  input  logic [OFF_W-1:0]    accOffset,
  input  logic [BE_W-1:0]     accBeN,
  input  logic [2*DATA_W-1:0] accWdata,
  input  logic [DATA_W-1:0]   dataPortIn,
  input  logic [DATA_W-1:0]   resetPortIn,
  input  logic [DATA_W-1:0]   auxPortIn,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  output logic                illegal,
  output logic                passThru,
  output logic                dataPortRd,
  output logic                dataPortWr,
  output logic                resetPortRd,
  output logic                resetPortWr,
  output logic                auxPortRd,
  output logic                auxPortWr,
  output logic [DATA_W-1:0]   wrData,
  output logic [PTR_W-1:0]    ptrSel,
  output logic                dwordMode
);

  localparam int AW = $clog2(STORE_BYTES);

  ctlStb_t stb;

  io_win_ctrl #(.OFF_W(OFF_W), .BE_W(BE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .softReset (softReset),
    .accValid  (accValid),
    .accWrite  (accWrite),
    .accOffset (accOffset),
    .accBeN    (accBeN),
    .stb       (stb),
    .dwordMode (dwordMode)
  );

  io_win_dp #(.DATA_W(DATA_W), .PTR_W(PTR_W), .STORE_BYTES(STORE_BYTES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .softReset   (softReset),
    .stb         (stb),
    .accOffset   (accOffset[AW-1:0]),
    .accWdata    (accWdata),
    .dataPortIn  (dataPortIn),
    .resetPortIn (resetPortIn),
    .auxPortIn   (auxPortIn),
    .rdData      (rdData),
    .rdValid     (rdValid),
    .illegal     (illegal),
    .passThru    (passThru),
    .dataPortRd  (dataPortRd),
    .dataPortWr  (dataPortWr),
    .resetPortRd (resetPortRd),
    .resetPortWr (resetPortWr),
    .auxPortRd   (auxPortRd),
    .auxPortWr   (auxPortWr),
    .wrData      (wrData),
    .ptrSel      (ptrSel)
  );

endmodule

// File: tb/io_win_dec_tb.sv
`timescale 1ns/1ps
module io_win_dec_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softReset = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [4:0]  accOffset = '0;
  logic [3:0]  accBeN = '1;
  logic [31:0] accWdata = '0;
  logic [15:0] dataPortIn = 16'hC0DE;
  logic [15:0] resetPortIn = 16'h7777;
  logic [15:0] auxPortIn = 16'hB0B0;
  logic [15:0] rdData, wrData;
  logic        rdValid, illegal, passThru, dwordMode;
  logic        dataPortRd, dataPortWr, resetPortRd, resetPortWr, auxPortRd, auxPortWr;
  logic [6:0]  ptrSel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  io_win_dec u_dut (
    .clk(clk), .rstN(rstN), .softReset(softReset), .accValid(accValid),
    .accWrite(accWrite), .accOffset(accOffset), .accBeN(accBeN), .accWdata(accWdata),
    .dataPortIn(dataPortIn), .resetPortIn(resetPortIn), .auxPortIn(auxPortIn),
    .rdData(rdData), .rdValid(rdValid), .illegal(illegal), .passThru(passThru),
    .dataPortRd(dataPortRd), .dataPortWr(dataPortWr), .resetPortRd(resetPortRd),
    .resetPortWr(resetPortWr), .auxPortRd(auxPortRd), .auxPortWr(auxPortWr),
    .wrData(wrData), .ptrSel(ptrSel), .dwordMode(dwordMode)
  );

  // Observed outcome code: 0 none, 1 read, 2 illegal, 3 dp rd, 4 dp wr,
  // 5 reset rd, 6 reset wr, 7 aux rd, 8 aux wr, 9 pass, 15 several pulses
  function automatic int obsTag();
    logic [7:0] p;
    p = {illegal, dataPortRd, dataPortWr, resetPortRd, resetPortWr, auxPortRd, auxPortWr, passThru};
    if ($countones(p) > 1) return 15;
    if (illegal)     return 2;
    if (dataPortRd)  return 3;
    if (dataPortWr)  return 4;
    if (resetPortRd) return 5;
    if (resetPortWr) return 6;
    if (auxPortRd)   return 7;
    if (auxPortWr)   return 8;
    if (passThru)    return 9;
    if (rdValid)     return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Present one access for one cycle; outputs are sampled one cycle later
  task automatic acc(input bit wr, input logic [4:0] off, input logic [3:0] be,
                     input logic [31:0] wd);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accOffset = off; accBeN = be; accWdata = wd;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; accBeN = '1; accWdata = '0;
  endtask

  // {req, wr, off, be, wdata, expected data, expected tag}
  localparam int NV = 29;
  localparam logic [65:0] VEC [NV] = '{
    {4'd3, 1'b1, 5'h00, 4'hC, 32'h0000BBAA, 16'h0000, 4'd0}, // R3 word write low pair
    {4'd3, 1'b1, 5'h02, 4'h3, 32'hDDCC0000, 16'h0000, 4'd0}, // R3 word write high pair
    {4'd3, 1'b1, 5'h0C, 4'hC, 32'h00002211, 16'h0000, 4'd0}, // R3
    {4'd2, 1'b0, 5'h00, 4'hE, 32'h0,        16'h00AA, 4'd1}, // R2 lane 0
    {4'd2, 1'b0, 5'h01, 4'hD, 32'h0,        16'h00BB, 4'd1}, // R2 lane 1
    {4'd2, 1'b0, 5'h02, 4'hB, 32'h0,        16'h00CC, 4'd1}, // R2 lane 2
    {4'd2, 1'b0, 5'h03, 4'h7, 32'h0,        16'h00DD, 4'd1}, // R2 lane 3
    {4'd3, 1'b0, 5'h00, 4'hC, 32'h0,        16'hBBAA, 4'd1}, // R3
    {4'd3, 1'b0, 5'h02, 4'h3, 32'h0,        16'hDDCC, 4'd1}, // R3
    {4'd3, 1'b0, 5'h0C, 4'hC, 32'h0,        16'h2211, 4'd1}, // R3
    {4'd4, 1'b1, 5'h12, 4'h3, 32'h12B40000, 16'h0000, 4'd0}, // R4 pointer write
    {4'd4, 1'b0, 5'h12, 4'h3, 32'h0,        16'h0034, 4'd1}, // R4 7-bit readback
    {4'd1, 1'b0, 5'h10, 4'hC, 32'h0,        16'hC0DE, 4'd3}, // R1
    {4'd1, 1'b1, 5'h10, 4'hC, 32'h00005A5A, 16'h5A5A, 4'd4}, // R1
    {4'd1, 1'b0, 5'h14, 4'hC, 32'h0,        16'h7777, 4'd5}, // R1
    {4'd1, 1'b1, 5'h14, 4'hC, 32'h00000001, 16'h0001, 4'd6}, // R1
    {4'd1, 1'b0, 5'h16, 4'h3, 32'h0,        16'hB0B0, 4'd7}, // R1
    {4'd1, 1'b1, 5'h16, 4'h3, 32'hABCD0000, 16'hABCD, 4'd8}, // R1 upper lanes
    {4'd5, 1'b0, 5'h18, 4'hC, 32'h0,        16'hFFFF, 4'd2}, // R5 reserved read
    {4'd5, 1'b1, 5'h1E, 4'h3, 32'hFFFFFFFF, 16'h0000, 4'd2}, // R5 reserved write
    {4'd5, 1'b0, 5'h10, 4'h3, 32'h0,        16'hFFFF, 4'd2}, // R5 wrong lanes
    {4'd5, 1'b0, 5'h01, 4'hC, 32'h0,        16'hFFFF, 4'd2}, // R5 odd word
    {4'd5, 1'b1, 5'h00, 4'hE, 32'h000000EE, 16'h0000, 4'd2}, // R5 byte write
    {4'd5, 1'b0, 5'h00, 4'hE, 32'h0,        16'h00AA, 4'd1}, // R5 store untouched
    {4'd5, 1'b0, 5'h10, 4'h0, 32'h0,        16'hFFFF, 4'd2}, // R5 32-bit read
    {4'd5, 1'b1, 5'h12, 4'hC, 32'h0000FFFF, 16'h0000, 4'd2}, // R5 pointer wrong lanes
    {4'd4, 1'b0, 5'h12, 4'h3, 32'h0,        16'h0034, 4'd1}, // R4 pointer untouched
    {4'd5, 1'b1, 5'h00, 4'h3, 32'h0000EEEE, 16'h0000, 4'd2}, // R5 word on wrong pair
    {4'd5, 1'b0, 5'h00, 4'hC, 32'h0,        16'hBBAA, 4'd1}  // R5 store untouched
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(obsTag() == 0 && !rdValid, "R9", "pulses after reset", 32'(obsTag()), 0);
    chk(dwordMode == 1'b0, "R9", "mode after reset", 32'(dwordMode), 0);
    chk(ptrSel == 7'd0, "R9", "pointer after reset", 32'(ptrSel), 0);
    chk(rdData == 16'h0, "R9", "rdData after reset", 32'(rdData), 0);

    for (int i = 0; i < NV; i++) begin
      logic [65:0] v;
      string rq;
      int tg;
      v = VEC[i];
      rq = $sformatf("R%0d", int'(v[65:62]));
      acc(v[61], v[60:56], v[55:52], v[51:20]);
      tg = obsTag();
      chk(tg == int'(v[3:0]), rq, $sformatf("vector %0d outcome", i), 32'(tg), 32'(v[3:0]));
      if (!v[61] && (v[3:0] == 1 || v[3:0] == 2 || v[3:0] == 3 || v[3:0] == 5 || v[3:0] == 7))
        chk(rdData == v[19:4] && rdValid, rq, $sformatf("vector %0d rdData", i),
            32'(rdData), 32'(v[19:4]));
      if (v[3:0] == 4 || v[3:0] == 6 || v[3:0] == 8)
        chk(wrData == v[19:4], rq, $sformatf("vector %0d wrData", i), 32'(wrData), 32'(v[19:4]));
    end
    chk(ptrSel == 7'h34, "R4", "ptrSel output", 32'(ptrSel), 32'h34);

    // R6 32-bit write enters sticky mode and still strobes the data port
    chk(dwordMode == 1'b0, "R6", "mode before switch", 32'(dwordMode), 0);
    acc(1'b1, 5'h10, 4'h0, 32'hFFFF0000);
    chk(obsTag() == 4, "R6", "switch strobe", 32'(obsTag()), 4);
    chk(wrData == 16'h0000, "R6", "switch wrData", 32'(wrData), 0);
    chk(dwordMode == 1'b1, "R6", "mode set", 32'(dwordMode), 1);

    // R8 accesses pass through untouched
    acc(1'b0, 5'h00, 4'hE, 32'h0);
    chk(obsTag() == 9 && !rdValid, "R8", "read passes", 32'(obsTag()), 9);
    acc(1'b1, 5'h12, 4'h3, 32'h00550000);
    chk(obsTag() == 9, "R8", "pointer write passes", 32'(obsTag()), 9);
    chk(ptrSel == 7'h34, "R8", "pointer kept", 32'(ptrSel), 32'h34);
    acc(1'b1, 5'h18, 4'h5, 32'h0);
    chk(obsTag() == 9, "R8", "odd access passes, not illegal", 32'(obsTag()), 9);

    // R7 stays set through accesses and idle time
    acc(1'b1, 5'h10, 4'h0, 32'h0);
    repeat (5) @(negedge clk);
    chk(dwordMode == 1'b1, "R7", "mode sticky", 32'(dwordMode), 1);

    // R7 / R4 software reset clears mode and pointer, keeps store
    softReset = 1'b1;
    @(negedge clk);
    softReset = 1'b0;
    chk(dwordMode == 1'b0, "R7", "soft reset clears mode", 32'(dwordMode), 0);
    chk(ptrSel == 7'd0, "R4", "soft reset clears pointer", 32'(ptrSel), 0);
    acc(1'b0, 5'h12, 4'h3, 32'h0);
    chk(rdData == 16'h0000 && obsTag() == 1, "R4", "pointer reads zero", 32'(rdData), 0);
    acc(1'b0, 5'h00, 4'hC, 32'h0);
    chk(rdData == 16'hBBAA, "R3", "store after soft reset", 32'(rdData), 32'hBBAA);

    // R4 full 7-bit pointer, then R9 hardware reset from a busy state
    acc(1'b1, 5'h12, 4'h3, 32'hFFFF0000);
    chk(ptrSel == 7'h7F, "R4", "pointer all ones", 32'(ptrSel), 32'h7F);
    acc(1'b1, 5'h10, 4'h0, 32'h0);
    chk(dwordMode == 1'b1, "R6", "mode set again", 32'(dwordMode), 1);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(dwordMode == 1'b0, "R7", "hardware reset clears mode", 32'(dwordMode), 0);
    chk(ptrSel == 7'd0, "R4", "hardware reset clears pointer", 32'(ptrSel), 0);
    chk(rdData == 16'h0, "R9", "rdData cleared", 32'(rdData), 0);
    acc(1'b0, 5'h02, 4'h3, 32'h0);
    chk(rdData == 16'h0000 && obsTag() == 1, "R9", "store cleared", 32'(rdData), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule